// File: doc/BRIEF.md
# Read Termination Window Calculator

This block derives the read on-die-termination window of a memory controller from training results. After read training, each chip select has a 4-bit read-sample delay, and each data octet of each chip select has a leveling value. A start pulse latches one packed delay word with the active chip-select and octet counts. The block then visits the chip selects in index order. It keeps the smallest and largest delay seen so far. It also pulls in octet leveling values for the chip selects that reach or exceed the running maximum delay, and it tracks the largest leveling phase among them.

When the scan ends, the block produces two timing fields in one cycle. The start field is taken from the minimum delay. The end field is the maximum delay plus a fixed margin plus half the largest phase. A one-cycle done pulse marks the result, and both fields hold their values until the next result. Leveling values arrive on a valid/ready stream. The block asks for exactly one value per octet for each chip select that qualifies, and for none otherwise.

Top module: `rd_odt_window`

## Requirements
- R1: Chip select n (n = 0..3) takes its delay from bits [8n+3:8n] of `sdly_word_i`. Bits [8n+7:8n+4] have no effect on any output.
- R2: With m the smallest delay among the active chip selects, let a = m-1, limited to at most 15. `odt_start_o` is (a-1) truncated to 4 bits. This gives 0xE for m=0, 0xF for m=1 and 0xD for m=15.
- R3: With M the largest delay and p the tracked phase, `odt_end_o` = M + 4 + (p+1)/2 + 1, using integer division and limited to at most 31.
- R4: The phase of a leveling value is its bits [7:6], read as 0..3. Bits [5:0] have no effect.
- R5: A chip select whose delay is greater than or equal to the running maximum takes exactly N leveling values, where N is the octet count. `ph_ready_o` is high only while such values are awaited. A chip select whose delay is below the running maximum takes no leveling values. The running maximum starts at 0, so chip select 0 always takes values.
- R6: A chip select whose delay equals the running maximum discards the phase tracked so far before its own values are taken. A strictly larger delay keeps the tracked phase.
- R7: `cs_cnt_i` and `oct_cnt_i` are sampled only with an accepted start. A chip-select count of 0 acts as 1 and a count above 4 acts as 4. An octet count of 0 acts as 1 and a count above 8 acts as 8.
- R8: `done_o` is high for exactly one cycle per accepted start. While it is low, `odt_start_o` and `odt_end_o` hold their values. A start pulse while `busy_o` is high has no effect.
- R9: After reset, `done_o`, `busy_o`, `ph_ready_o`, `odt_start_o` and `odt_end_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted while idle |
| sdly_word_i | input | 32 | Packed read-sample delays, one byte lane per chip select |
| cs_cnt_i | input | 3 | Number of active chip selects |
| oct_cnt_i | input | 4 | Number of data octets |
| ph_valid_i | input | 1 | Leveling value valid |
| ph_level_i | input | 8 | Leveling value of the current octet |
| ph_ready_o | output | 1 | Leveling value accepted this cycle when valid |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle result strobe |
| odt_start_o | output | 4 | Termination window start field |
| odt_end_o | output | 5 | Termination window end field |

## Verification
The bench targets the tie rule between chip selects. A design that kept the earlier phase would report an end field two units too large. The bench also drives descending delays, where a design that pulled leveling values for every chip select would stall waiting for values that never come. Minimum delays of 0, 1 and 15 exercise the double minus-one with saturation, which shows up wrong by one or by a sign wrap. Set upper nibbles, set low level bits, out-of-range counts and a start pulse during a scan each change the result if the design fails to ignore or clamp them.

// File: rtl/rd_odt_pkg.sv
package rd_odt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EVAL,
    ST_SCAN,
    ST_FINAL
  } odt_state_e;

  localparam int unsigned ARITH_W = 8;
  localparam logic signed [ARITH_W-1:0] PH_FLOOR = -8'sd128;
endpackage

// File: rtl/rd_odt_field_sel.sv
module rd_odt_field_sel #(
  parameter int unsigned NUM_CS = 4,
  parameter int unsigned STRIDE = 8,
  parameter int unsigned DLY_W  = 4,
  localparam int unsigned WORD_W = NUM_CS * STRIDE,
  localparam int unsigned IDX_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [DLY_W-1:0]  dly_o
);
  logic [DLY_W-1:0] lane [NUM_CS];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_lane
    assign lane[g] = word_i[g*STRIDE +: DLY_W];
  end

  assign dly_o = lane[idx_i];
endmodule

// File: rtl/rd_odt_phase_max.sv
module rd_odt_phase_max
  import rd_odt_pkg::*;
#(
  parameter int unsigned LVL_W  = 8,
  parameter int unsigned PH_LSB = 6,
  parameter int unsigned PH_W   = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clear_i,
  input  logic                      sample_i,
  input  logic [LVL_W-1:0]          level_i,
  output logic signed [ARITH_W-1:0] ph_max_o
);
  logic signed [ARITH_W-1:0] ph_new;

  assign ph_new = signed'({{(ARITH_W-PH_W){1'b0}}, level_i[PH_LSB +: PH_W]});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_max_o <= PH_FLOOR;
    end else if (clear_i) begin
      ph_max_o <= PH_FLOOR;
    end else if (sample_i && (ph_new >= ph_max_o)) begin
      ph_max_o <= ph_new;
    end
  end
endmodule

// File: rtl/rd_odt_window_calc.sv
module rd_odt_window_calc
  import rd_odt_pkg::*;
#(
  parameter int unsigned DLY_W   = 4,
  parameter int unsigned START_W = 4,
  parameter int unsigned END_W   = 5,
  parameter int unsigned MARGIN  = 4,
  localparam int unsigned MIN_W  = DLY_W + 1
) (
  input  logic [MIN_W-1:0]          min_i,
  input  logic [DLY_W-1:0]          max_i,
  input  logic signed [ARITH_W-1:0] ph_i,
  output logic [START_W-1:0]        start_o,
  output logic [END_W-1:0]          end_o
);
  localparam logic signed [ARITH_W-1:0] START_SAT = ARITH_W'((1 << START_W) - 1);
  localparam logic signed [ARITH_W-1:0] END_SAT   = ARITH_W'((1 << END_W) - 1);
  localparam logic signed [ARITH_W-1:0] PAD       = ARITH_W'(MARGIN + 1);

  logic signed [ARITH_W-1:0] mn_s, mn_adj, st_full;
  logic signed [ARITH_W-1:0] mx_s, ph_half, mx_adj;

  always_comb begin
    mn_s   = signed'(ARITH_W'(min_i));
    mn_adj = mn_s - 8'sd1;
    if (mn_adj >= START_SAT) mn_adj = START_SAT;
    st_full = mn_adj - 8'sd1;
    start_o = st_full[START_W-1:0];

    mx_s    = signed'(ARITH_W'(max_i));
    ph_half = (ph_i + 8'sd1) / 8'sd2;
    mx_adj  = mx_s + PAD + ph_half;
    if (mx_adj >= END_SAT) mx_adj = END_SAT;
    end_o = mx_adj[END_W-1:0];
  end
endmodule

// File: rtl/rd_odt_window.sv
module rd_odt_window
  import rd_odt_pkg::*;
#(
  parameter int unsigned NUM_CS  = 4,
  parameter int unsigned STRIDE  = 8,
  parameter int unsigned DLY_W   = 4,
  parameter int unsigned MAX_OCT = 8,
  parameter int unsigned LVL_W   = 8,
  parameter int unsigned PH_LSB  = 6,
  parameter int unsigned PH_W    = 2,
  parameter int unsigned START_W = 4,
  parameter int unsigned END_W   = 5,
  parameter int unsigned MARGIN  = 4,
  localparam int unsigned WORD_W    = NUM_CS * STRIDE,
  localparam int unsigned CS_IDX_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int unsigned CS_CNT_W  = $clog2(NUM_CS + 1),
  localparam int unsigned OCT_IDX_W = (MAX_OCT > 1) ? $clog2(MAX_OCT) : 1,
  localparam int unsigned OCT_CNT_W = $clog2(MAX_OCT + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [WORD_W-1:0]    sdly_word_i,
  input  logic [CS_CNT_W-1:0]  cs_cnt_i,
  input  logic [OCT_CNT_W-1:0] oct_cnt_i,
  input  logic                 ph_valid_i,
  input  logic [LVL_W-1:0]     ph_level_i,
  output logic                 ph_ready_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [START_W-1:0]   odt_start_o,
  output logic [END_W-1:0]     odt_end_o
);
  localparam int unsigned MIN_W = DLY_W + 1;
  localparam logic [MIN_W-1:0] MIN_INIT = MIN_W'((1 << MIN_W) - 1);

  odt_state_e state_q;
  logic [WORD_W-1:0]    word_q;
  logic [CS_IDX_W-1:0]  cs_idx_q, cs_last_q, cs_last_d;
  logic [OCT_IDX_W-1:0] oct_idx_q, oct_last_q, oct_last_d;
  logic [DLY_W-1:0]     max_q, dly;
  logic [MIN_W-1:0]     min_q;
  logic                 done_q;
  logic [START_W-1:0]   start_q, start_calc;
  logic [END_W-1:0]     end_q, end_calc;
  logic signed [ARITH_W-1:0] ph_max;
  logic accept, qualify, tie, ph_take, ph_clr, cs_last_hit, oct_last_hit;

  assign accept   = (state_q == ST_IDLE) && start_i;
  assign qualify  = dly >= max_q;
  assign tie      = dly == max_q;
  assign ph_take  = (state_q == ST_SCAN) && ph_valid_i;
  assign ph_clr   = accept || ((state_q == ST_EVAL) && tie);
  assign cs_last_hit  = cs_idx_q == cs_last_q;
  assign oct_last_hit = oct_idx_q == oct_last_q;

  // range-limited counts, stored as last index
  always_comb begin
    if (cs_cnt_i == '0) cs_last_d = '0;
    else if (cs_cnt_i > CS_CNT_W'(NUM_CS)) cs_last_d = CS_IDX_W'(NUM_CS - 1);
    else cs_last_d = CS_IDX_W'(cs_cnt_i - 1'b1);
    if (oct_cnt_i == '0) oct_last_d = '0;
    else if (oct_cnt_i > OCT_CNT_W'(MAX_OCT)) oct_last_d = OCT_IDX_W'(MAX_OCT - 1);
    else oct_last_d = OCT_IDX_W'(oct_cnt_i - 1'b1);
  end

  rd_odt_field_sel #(
    .NUM_CS (NUM_CS),
    .STRIDE (STRIDE),
    .DLY_W  (DLY_W)
  ) u_sel (
    .word_i (word_q),
    .idx_i  (cs_idx_q),
    .dly_o  (dly)
  );

  rd_odt_phase_max #(
    .LVL_W  (LVL_W),
    .PH_LSB (PH_LSB),
    .PH_W   (PH_W)
  ) u_ph (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (ph_clr),
    .sample_i (ph_take),
    .level_i  (ph_level_i),
    .ph_max_o (ph_max)
  );

  rd_odt_window_calc #(
    .DLY_W   (DLY_W),
    .START_W (START_W),
    .END_W   (END_W),
    .MARGIN  (MARGIN)
  ) u_calc (
    .min_i   (min_q),
    .max_i   (max_q),
    .ph_i    (ph_max),
    .start_o (start_calc),
    .end_o   (end_calc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      word_q     <= '0;
      cs_idx_q   <= '0;
      cs_last_q  <= '0;
      oct_idx_q  <= '0;
      oct_last_q <= '0;
      max_q      <= '0;
      min_q      <= MIN_INIT;
      done_q     <= 1'b0;
      start_q    <= '0;
      end_q      <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            word_q     <= sdly_word_i;
            cs_last_q  <= cs_last_d;
            oct_last_q <= oct_last_d;
            cs_idx_q   <= '0;
            max_q      <= '0;
            min_q      <= MIN_INIT;
            state_q    <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          if (MIN_W'(dly) < min_q) min_q <= MIN_W'(dly);
          if (qualify) begin
            if (!tie) max_q <= dly;
            oct_idx_q <= '0;
            state_q   <= ST_SCAN;
          end else if (cs_last_hit) begin
            state_q <= ST_FINAL;
          end else begin
            cs_idx_q <= cs_idx_q + 1'b1;
          end
        end
        ST_SCAN: begin
          if (ph_valid_i) begin
            if (!oct_last_hit) begin
              oct_idx_q <= oct_idx_q + 1'b1;
            end else if (cs_last_hit) begin
              state_q <= ST_FINAL;
            end else begin
              cs_idx_q <= cs_idx_q + 1'b1;
              state_q  <= ST_EVAL;
            end
          end
        end
        ST_FINAL: begin
          start_q <= start_calc;
          end_q   <= end_calc;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ph_ready_o  = state_q == ST_SCAN;
  assign busy_o      = state_q != ST_IDLE;
  assign done_o      = done_q;
  assign odt_start_o = start_q;
  assign odt_end_o   = end_q;
endmodule

// File: rtl/rd_odt_window_chk.sv
module rd_odt_window_chk #(
  parameter int unsigned START_W = 4,
  parameter int unsigned END_W   = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               ph_ready_o,
  input logic               busy_o,
  input logic               done_o,
  input logic [START_W-1:0] odt_start_o,
  input logic [END_W-1:0]   odt_end_o
);
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (done_o || ($stable(odt_start_o) && $stable(odt_end_o))));

  // R8
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R8
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !ph_ready_o) |=> (busy_o || done_o));

  // R5
  ready_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_ready_o |-> busy_o);

  // R3
  end_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (odt_end_o >= END_W'(5)));
endmodule

bind rd_odt_window rd_odt_window_chk #(
  .START_W (START_W),
  .END_W   (END_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .ph_ready_o  (ph_ready_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .odt_start_o (odt_start_o),
  .odt_end_o   (odt_end_o)
);

// File: tb/rd_odt_window_test.sv
module rd_odt_window_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] sdly_word_i = '0;
  logic [2:0]  cs_cnt_i = '0;
  logic [3:0]  oct_cnt_i = '0;
  logic        ph_valid_i = 1'b0;
  logic [7:0]  ph_level_i = '0;
  logic        ph_ready_o, busy_o, done_o;
  logic [3:0]  odt_start_o;
  logic [4:0]  odt_end_o;

  int checks = 0;
  int errors = 0;
  logic [8:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] lv [32];

  always #2.5 clk_i = ~clk_i;

  rd_odt_window uut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected results on each done strobe
  logic done_prev = 1'b0;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (done_o && done_prev) check(1'b0, "R8 done width", 1, 0);
      if (done_o) begin
        if (exp_q.size() == 0) check(1'b0, "R8 unexpected done", 1, 0);
        else begin
          logic [8:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(odt_start_o == e[8:5], {t, " start"}, odt_start_o, e[8:5]);
          check(odt_end_o == e[4:0], {t, " end"}, odt_end_o, e[4:0]);
        end
      end
      done_prev <= done_o;
    end
  end

  // driver: models the result from the requirements, then feeds the levels
  task automatic run(input logic [31:0] w, input int ncs, input int noct,
                     input string tag, input bit disturb);
    int ecs, eoct, mn, mx, ph, d, n, st, en;
    logic [7:0] feed [$];
    ecs  = (ncs == 0) ? 1 : (ncs > 4 ? 4 : ncs);
    eoct = (noct == 0) ? 1 : (noct > 8 ? 8 : noct);
    mn = 31; mx = 0; ph = -128;
    for (int c = 0; c < ecs; c++) begin
      d = (w >> (8*c)) & 15;
      if (d >= mx) begin
        if (d == mx) ph = -128; else mx = d;
        for (int o = 0; o < eoct; o++) begin
          feed.push_back(lv[c*8+o]);
          if (int'(lv[c*8+o][7:6]) >= ph) ph = int'(lv[c*8+o][7:6]);
        end
      end
      if (d < mn) mn = d;
    end
    mn = mn - 1; if (mn >= 15) mn = 15;
    st = (mn - 1) & 15;
    en = mx + 4 + (ph + 1) / 2 + 1; if (en >= 31) en = 31;
    exp_q.push_back({4'(st), 5'(en)});
    tag_q.push_back(tag);
    @(negedge clk_i);
    start_i = 1'b1; sdly_word_i = w; cs_cnt_i = 3'(ncs); oct_cnt_i = 4'(noct);
    @(negedge clk_i);
    start_i = 1'b0;
    if (disturb) begin
      start_i = 1'b1; sdly_word_i = 32'h0000_0000; cs_cnt_i = 3'd1; oct_cnt_i = 4'd1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    while (feed.size() > 0) begin
      n = 0;
      while (!ph_ready_o && n < 50) begin @(negedge clk_i); n++; end
      ph_valid_i = 1'b1; ph_level_i = feed.pop_front();
      @(negedge clk_i);
      ph_valid_i = 1'b0;
    end
    n = 0;
    while (busy_o && n < 50) begin @(negedge clk_i); n++; end
    // R5: no extra leveling values requested once fed
    check(!busy_o, {tag, " R5 scan end"}, busy_o, 0);
    @(negedge clk_i);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin @(posedge clk_i); cyc++; end
    check(1'b0, "watchdog", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] s0;
    logic [4:0] e0;
    foreach (lv[i]) lv[i] = 8'h00;
    repeat (3) @(negedge clk_i);
    // R9 reset values
    check(!done_o && !busy_o && !ph_ready_o, "R9 flags", {done_o, busy_o, ph_ready_o}, 0);
    check(odt_start_o == 0 && odt_end_o == 0, "R9 fields", {odt_start_o, odt_end_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 R3 R5: ascending delays, every cs scanned, phase kept across cs
    lv[0] = 8'h40; lv[8] = 8'h80; lv[24] = 8'h40; lv[25] = 8'h40;
    run(32'h0403_0201, 4, 2, "R1 R3 ascending", 1'b0);
    // R5 R2: descending, only cs0 scanned, min 3
    foreach (lv[i]) lv[i] = 8'h00;
    lv[0] = 8'hC0;
    run(32'h0305_0709, 4, 3, "R5 descending", 1'b0);
    // R6 tie discards earlier phase
    foreach (lv[i]) lv[i] = 8'h00;
    lv[0] = 8'hC0; lv[1] = 8'hC0;
    run(32'h0000_0505, 2, 2, "R6 tie", 1'b0);
    // R6 strictly larger keeps phase
    run(32'h0000_0605, 2, 2, "R6 larger", 1'b0);
    // R2 min 0 and min 1
    foreach (lv[i]) lv[i] = 8'h00;
    run(32'h0000_0000, 1, 1, "R2 min0", 1'b0);
    run(32'h0000_0001, 1, 1, "R2 min1", 1'b0);
    // R1 R4: upper nibbles and low level bits ignored
    lv[0] = 8'h3F;
    run(32'hF0F0_F0FF, 1, 1, "R1 R4 ignored bits", 1'b0);
    lv[0] = 8'hFF;
    run(32'h0000_00AF, 1, 1, "R4 top phase", 1'b0);
    // R7 zero and oversize counts
    foreach (lv[i]) lv[i] = 8'h00;
    lv[16] = 8'hC0;
    run(32'h0201_0000, 0, 0, "R7 zero counts", 1'b0);
    lv[7] = 8'hC0; lv[31] = 8'h80;
    run(32'h0101_0101, 7, 12, "R7 oversize counts", 1'b0);
    // R8 start during scan ignored
    foreach (lv[i]) lv[i] = 8'h00;
    lv[1] = 8'h80;
    run(32'h0000_0C0A, 2, 2, "R8 busy start", 1'b1);
    // R8 hold after done
    s0 = odt_start_o; e0 = odt_end_o;
    repeat (5) @(negedge clk_i);
    check(odt_start_o == s0 && odt_end_o == e0, "R8 hold", {odt_start_o, odt_end_o}, {s0, e0});
    check(exp_q.size() == 0, "R8 results pending", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule